// File: doc/BRIEF.md
# Overcurrent Disable Timer Controller

This block watches a synchronous flag from an analog current-limit comparator and decides when the output stage of a supply must be switched off. It times an over-limit event with a prescaled tick. If the flag stays high for the whole disable window (about 45 ms in a real system, a parameter here), the block latches an overcurrent fault and turns the output off. Short events, such as inrush at start-up or during a change of output voltage, are allowed to pass without a trip.

Software can arm a one-shot raised limit. If the arm bit is set when an event begins, the limit-select output asks for 125% of the nominal limit for the first quarter of the disable window. The limit then drops back to nominal, and the block pulses a request that clears the arm bit in the register file. After a trip the output stays off and the enable bit has no effect until the register interface sends a fault-clear pulse, which it does once a status read has completed.

Top module: `ocp_timer_ctrl`

## Requirements
- R1: Synchronous active-high reset. During reset and on the first cycle after it, `out_en_o`=0, `out_off_o`=1, `ocp_fault_o`=0, `limit_sel_o`=0 (nominal) and `boost_clr_o`=0.
- R2: An event is a run of cycles in which `over_limit_i` and `out_en_o` are both 1. When the run reaches TRIP_TICKS*PRESCALE consecutive clock edges, `ocp_fault_o` becomes 1 and `out_en_o` becomes 0 after that edge.
- R3: A run shorter than TRIP_TICKS*PRESCALE edges never trips. A single cycle without the event resets the timing, so the next run starts again from zero.
- R4: If `boost_req_i` is 1 on the first edge of an event, `limit_sel_o` is 1 (raised, 125%) after edges 1 to Q*PRESCALE-1 of the event, where Q = TRIP_TICKS>>2. It is 0 from edge Q*PRESCALE onward.
- R5: When a raised window ends at edge Q*PRESCALE, `boost_clr_o` is 1 for exactly the one cycle after that edge.
- R6: If `boost_req_i` is 0 on the first edge of an event, `limit_sel_o` stays 0 and `boost_clr_o` stays 0 for the whole event, even if `boost_req_i` rises during the event.
- R7: While `ocp_fault_o` is 1, `out_en_o` stays 0 whatever `enable_i` does. A `fault_clr_i` pulse clears the fault at the next edge, and `out_en_o` then follows `enable_i` at that same edge.
- R8: `out_off_o` is always the inverse of `out_en_o`, so `ocp_fault_o`=1 implies `out_off_o`=1.
- R9: With no fault latched, `out_en_o` takes the value of `enable_i` one edge later. `over_limit_i` has no effect while `out_en_o` is 0.
- R10: If a raised event ends before edge Q*PRESCALE, `limit_sel_o` returns to 0 on the next edge and `boost_clr_o` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| over_limit_i | input | 1 | Synchronised current-limit comparator flag |
| enable_i | input | 1 | Output enable bit from the register file |
| boost_req_i | input | 1 | Arm bit for the one-shot raised limit |
| fault_clr_i | input | 1 | One-cycle fault clear, sent after a status read |
| out_en_o | output | 1 | Output stage enable |
| limit_sel_o | output | 1 | Limit select: 0 nominal, 1 raised to 125% |
| ocp_fault_o | output | 1 | Latched overcurrent fault |
| out_off_o | output | 1 | Output-disabled status flag |
| boost_clr_o | output | 1 | One-cycle request to clear the arm bit |

## Verification
The assertions check on every cycle that:
- the prescale and window counters stay in range;
- a terminal count always latches the fault and drops the output;
- a latched fault holds, and keeps the output off, until it is cleared;
- the disabled flag covers the fault;
- a clear request is never issued while the raised limit is still selected.

Only the bench scenarios can show the timing. These cover the exact edge counts at which the raised window closes and the trip occurs, and the fact that runs one edge short of the window never trip. They also show that the arm bit is sampled only at the start of an event and survives an event that ends early, and that the enable bit is ignored until a clear arrives.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  typedef enum logic {
    LIM_NOM    = 1'b0,
    LIM_RAISED = 1'b1
  } limit_sel_e;

  function automatic int quarter_of(input int ticks);
    return ticks >> 2;
  endfunction

endpackage

// File: rtl/ocp_tick_gen.sv
module ocp_tick_gen #(
  parameter int PRESCALE = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  // phase restarts at every event start so the window is edge-exact
  always_ff @(posedge clk) begin
    if (rst || !run_i) pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && (pre_q == LAST);

  AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
    pre_q <= LAST); // R2

endmodule

// File: rtl/ocp_window_cnt.sv
module ocp_window_cnt #(
  parameter int TRIP_TICKS = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  output logic quarter_hit_o,
  output logic trip_hit_o
);
  import ocp_pkg::*;

  localparam int QUARTER = quarter_of(TRIP_TICKS);
  localparam int CW = $clog2(TRIP_TICKS + 1);
  localparam logic [CW-1:0] Q_LAST = CW'(QUARTER - 1);
  localparam logic [CW-1:0] T_LAST = CW'(TRIP_TICKS - 1);
  localparam logic [CW-1:0] T_MAX  = CW'(TRIP_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign quarter_hit_o = tick_i && (cnt_q == Q_LAST);
  assign trip_hit_o    = tick_i && (cnt_q == T_LAST);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= T_MAX); // R2

endmodule

// File: rtl/ocp_boost_ctl.sv
module ocp_boost_ctl (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic start_i,
  input  logic boost_req_i,
  input  logic quarter_hit_i,
  output logic limit_hi_o,
  output logic boost_clr_o
);
  logic limit_hi_q, boost_clr_q;
  logic armed, raise_nx, clr_nx;

  // arm bit sampled only on the first edge of an event
  always_comb begin
    armed    = limit_hi_q || (start_i && boost_req_i);
    raise_nx = run_i && armed && !quarter_hit_i;
    clr_nx   = run_i && armed && quarter_hit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_hi_q  <= 1'b0;
      boost_clr_q <= 1'b0;
    end else begin
      limit_hi_q  <= raise_nx;
      boost_clr_q <= clr_nx;
    end
  end

  assign limit_hi_o  = limit_hi_q;
  assign boost_clr_o = boost_clr_q;

  AST_CLR_AFTER_RAISE: assert property (@(posedge clk) disable iff (rst)
    boost_clr_q |-> !limit_hi_q); // R5

  AST_RAISE_ONLY_ARMED: assert property (@(posedge clk) disable iff (rst)
    $rose(limit_hi_q) |-> $past(boost_req_i)); // R4

endmodule

// File: rtl/ocp_out_ctl.sv
module ocp_out_ctl (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  input  logic fault_clr_i,
  input  logic trip_hit_i,
  output logic out_en_o,
  output logic fault_o,
  output logic out_off_o
);
  logic fault_q, out_en_q, out_off_q;
  logic fault_nx, en_nx;

  always_comb begin
    fault_nx = trip_hit_i || (fault_q && !fault_clr_i);
    en_nx    = enable_i && !fault_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_q   <= 1'b0;
      out_en_q  <= 1'b0;
      out_off_q <= 1'b1;
    end else begin
      fault_q   <= fault_nx;
      out_en_q  <= en_nx;
      out_off_q <= !en_nx;
    end
  end

  assign out_en_o  = out_en_q;
  assign fault_o   = fault_q;
  assign out_off_o = out_off_q;

  AST_TRIP_SETS_FAULT: assert property (@(posedge clk) disable iff (rst)
    trip_hit_i |=> (fault_q && !out_en_q)); // R2

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !fault_clr_i) |=> fault_q); // R7

  AST_EN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (fault_q && !fault_clr_i) |=> !out_en_q); // R7

  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> out_off_q); // R8

endmodule

// File: rtl/ocp_timer_ctrl.sv
module ocp_timer_ctrl #(
  parameter int PRESCALE   = 1000,
  parameter int TRIP_TICKS = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic over_limit_i,
  input  logic enable_i,
  input  logic boost_req_i,
  input  logic fault_clr_i,
  output logic out_en_o,
  output logic limit_sel_o,
  output logic ocp_fault_o,
  output logic out_off_o,
  output logic boost_clr_o
);
  import ocp_pkg::*;

  logic active, in_evt_q, start;
  logic tick, quarter_hit, trip_hit, limit_hi;
  limit_sel_e lim_sel;

  assign active = over_limit_i && out_en_o;
  assign start  = active && !in_evt_q;

  always_ff @(posedge clk) begin
    if (rst) in_evt_q <= 1'b0;
    else in_evt_q <= active;
  end

  ocp_tick_gen #(.PRESCALE(PRESCALE)) i_tick (
    .clk(clk), .rst(rst), .run_i(active), .tick_o(tick)
  );

  ocp_window_cnt #(.TRIP_TICKS(TRIP_TICKS)) i_window (
    .clk(clk), .rst(rst), .run_i(active), .tick_i(tick),
    .quarter_hit_o(quarter_hit), .trip_hit_o(trip_hit)
  );

  ocp_boost_ctl i_boost (
    .clk(clk), .rst(rst), .run_i(active), .start_i(start),
    .boost_req_i(boost_req_i), .quarter_hit_i(quarter_hit),
    .limit_hi_o(limit_hi), .boost_clr_o(boost_clr_o)
  );

  ocp_out_ctl i_out (
    .clk(clk), .rst(rst), .enable_i(enable_i), .fault_clr_i(fault_clr_i),
    .trip_hit_i(trip_hit), .out_en_o(out_en_o), .fault_o(ocp_fault_o),
    .out_off_o(out_off_o)
  );

  assign lim_sel     = limit_hi ? LIM_RAISED : LIM_NOM;
  assign limit_sel_o = lim_sel;

  AST_TRIP_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
    $rose(ocp_fault_o) |-> $past(over_limit_i)); // R9

endmodule

// File: tb/test_ocp_timer_ctrl.sv
module test_ocp_timer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P  = 2;
  localparam int T  = 8;
  localparam int QP = (T >> 2) * P;
  localparam int TP = T * P;

  typedef struct {
    bit en, lim, fault, off, bclr;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ol = 1'b0, en = 1'b0, br = 1'b0, clr = 1'b0;
  logic out_en, lim_sel, fault, out_off, bclr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_timer_ctrl #(.PRESCALE(P), .TRIP_TICKS(T)) i_ocp_timer_ctrl (
    .clk(clk), .rst(rst), .over_limit_i(ol), .enable_i(en),
    .boost_req_i(br), .fault_clr_i(clr), .out_en_o(out_en),
    .limit_sel_o(lim_sel), .ocp_fault_o(fault), .out_off_o(out_off),
    .boost_clr_o(bclr)
  );

  exp_t q[$];
  int checks = 0, fails = 0;
  bit sw_boost = 1'b0;

  // reference model state
  bit m_en = 0, m_fault = 0, m_armed = 0;
  int m_run = 0;

  task automatic chk(input bit act, input bit exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: applies inputs for the next edge and pushes the expected result
  task automatic step(input bit r_i, input bit ol_i, input bit en_i,
                      input bit clr_i, input string tag);
    exp_t e;
    bit active;
    @(negedge clk);
    rst = r_i; ol = ol_i; en = en_i; clr = clr_i; br = sw_boost;
    e.tag = tag;
    if (r_i) begin
      m_en = 0; m_fault = 0; m_armed = 0; m_run = 0;
      e.lim = 0; e.bclr = 0;
    end else begin
      active = ol_i && m_en;
      if (active) begin
        if (m_run == 0) m_armed = sw_boost;
        m_run++;
      end else begin
        m_run = 0; m_armed = 0;
      end
      e.lim  = active && m_armed && (m_run < QP);
      e.bclr = active && m_armed && (m_run == QP);
      if (active && m_run == TP) m_fault = 1;
      else if (clr_i) m_fault = 0;
      m_en = en_i && !m_fault;
      if (e.bclr) sw_boost = 1'b0;
    end
    e.en = m_en; e.fault = m_fault; e.off = !m_en;
    q.push_back(e);
  endtask

  task automatic run(input int n, input bit ol_i, input bit en_i, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, ol_i, en_i, 1'b0, tag);
  endtask

  // monitor: compares just after each active edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(out_en,  e.en,    "out_en",    e.tag);
      chk(lim_sel, e.lim,   "limit_sel", e.tag);
      chk(fault,   e.fault, "ocp_fault", e.tag);
      chk(out_off, e.off,   "out_off",   e.tag);
      chk(bclr,    e.bclr,  "boost_clr", e.tag);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R1");
    run(2, 1'b0, 1'b0, "R1");
    // over-limit with the output off has no effect
    run(3, 1'b1, 1'b0, "R9");
    run(3, 1'b0, 1'b1, "R9");
    // runs one edge short of the window, split by a single quiet cycle
    run(TP - 1, 1'b1, 1'b1, "R3");
    run(1, 1'b0, 1'b1, "R3");
    run(TP - 1, 1'b1, 1'b1, "R3");
    run(2, 1'b0, 1'b1, "R3");
    // armed event: raised window then auto-clear request
    sw_boost = 1'b1;
    run(QP + 4, 1'b1, 1'b1, "R4");
    run(2, 1'b0, 1'b1, "R5");
    // unarmed event, arm bit set mid-event is ignored
    run(3, 1'b1, 1'b1, "R6");
    sw_boost = 1'b1;
    run(5, 1'b1, 1'b1, "R6");
    run(2, 1'b0, 1'b1, "R6");
    // armed event that ends early keeps the arm bit
    run(QP - 2, 1'b1, 1'b1, "R10");
    run(2, 1'b0, 1'b1, "R10");
    // full trip with the raised window at its head
    run(TP + 3, 1'b1, 1'b1, "R2");
    run(4, 1'b0, 1'b1, "R7");
    run(2, 1'b1, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R7");
    run(3, 1'b0, 1'b1, "R7");
    run(2, 1'b0, 1'b0, "R9");
    // second trip without arm, then reset mid-fault
    run(2, 1'b0, 1'b1, "R9");
    run(TP + 1, 1'b1, 1'b1, "R2");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R1");
    run(2, 1'b0, 1'b1, "R1");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule